// File: doc/BRIEF.md
# Audio DSP Host Port Controller

This block is the device side of a byte-wide host interface to an audio signal processor. A host on an 8-bit I/O bus uses a 2-bit address with separate read and write strobes to reach three ports: a reset port, a command port and a reply port. The command port takes command bytes on writes and returns a busy flag on reads. The reply port returns reply bytes from a small output queue, and a separate status address reports whether a reply byte is waiting.

The host brings the device up with a handshake. It writes 1 to the reset port, waits, and then writes 0. When the device is released it queues a ready byte, 0xAA. The host then sends a version query and reads two reply bytes, first the major number and then the minor number. It accepts the device only if the major number is at least 4, and it may repeat the reset handshake several times before it gives up. Every accepted command byte makes the device busy for a set number of cycles, which models how long the processor takes to handle it. Command bytes that the device does not recognise are consumed and produce no reply.

Top module: `dsp_host_port`

## Requirements
- R1: After `rstN` is released, a read of address 1 (busy status) returns 0x00, a read of address 3 (reply status) returns 0x00, and a read of address 2 (reply data) on the empty queue returns 0xFF.
- R2: A write to address 0 with bit 0 set puts the device into hold. During hold, address 1 reads 0x80, the reply queue is emptied, and command writes to address 1 are discarded.
- R3: A write to address 0 with bit 0 clear ends the hold and queues the byte 0xAA in the same cycle. The same write made when the device is not in hold has no effect.
- R4: Bit 7 of address 3 is 1 exactly when the reply queue holds at least one byte. Bits 6 to 0 read as 0.
- R5: A read of address 2 returns the oldest queued byte and removes it from the queue. A read of address 2 on an empty queue returns 0xFF and changes nothing.
- R6: A write to address 1 is accepted only when address 1 bit 7 reads 0. After an accepted write, bit 7 of address 1 reads 1 for exactly BUSY_CYCLES cycles.
- R7: The command byte 0xE1 queues VER_MAJOR (default 4) and then VER_MINOR (default 5). The minor byte enters the queue one cycle after the major byte.
- R8: Any accepted command byte other than 0xE1 queues nothing, but it still starts the busy period.
- R9: A write to address 1 made while address 1 bit 7 reads 1 is discarded.
- R10: The reply queue holds FIFO_DEPTH bytes (default 4). A byte pushed while the queue is full is dropped, and the bytes already queued keep their order.
- R11: Entering hold cancels a minor version byte that is still waiting to be queued, so that after release only 0xAA is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port address: 0 reset, 1 command/busy, 2 reply data, 3 reply status |
| rdStb | input | 1 | Read strobe, one cycle per access |
| wrStb | input | 1 | Write strobe, one cycle per access |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data, valid while rdStb is high |

## Verification
Two events can fall in the same cycle. One is a host read that pops the queue while the delayed minor version byte is pushed. The other is a hold request that arrives in the cycle the minor byte is due. The bench provokes the first by reading reply data in the cycle right after a version query is written, and then checks that the major byte is returned and that the minor byte is still waiting. It provokes the second by writing the hold command straight after the query, and then checks that only 0xAA appears after release. An exhaustive sweep over all 256 command values checks that only 0xE1 produces a reply.

// File: rtl/dsp_host_pkg.sv
package dsp_host_pkg;
  localparam logic [1:0] PORT_RESET  = 2'd0;
  localparam logic [1:0] PORT_CMD    = 2'd1;
  localparam logic [1:0] PORT_REPLY  = 2'd2;
  localparam logic [1:0] PORT_RSTAT  = 2'd3;

  localparam logic [7:0] READY_BYTE  = 8'hAA;
  localparam logic [7:0] EMPTY_BYTE  = 8'hFF;

  typedef enum logic [1:0] {
    SRC_READY = 2'd0,
    SRC_MAJOR = 2'd1,
    SRC_MINOR = 2'd2
  } pushSrc_e;

  typedef struct packed {
    logic     flush;
    logic     push;
    pushSrc_e src;
    logic     pop;
  } queueCtl_t;
endpackage

// File: rtl/dsp_host_ctrl.sv
module dsp_host_ctrl
  import dsp_host_pkg::*;
#(
  parameter int         BUSY_CYCLES = 4,
  parameter logic [7:0] CMD_VERSION = 8'hE1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  output queueCtl_t  qCtl,
  output logic       heldFlag,
  output logic       busyFlag
);
  localparam int BCNT_W = $clog2(BUSY_CYCLES + 1);

  logic [BCNT_W-1:0] busyCnt;
  logic              minorPend;
  logic              rstWrite, cmdAccept, holdReq;

  assign busyFlag  = heldFlag || (busyCnt != '0);
  assign rstWrite  = wrStb && (addr == PORT_RESET);
  assign holdReq   = rstWrite && wrData[0];
  assign cmdAccept = wrStb && (addr == PORT_CMD) && !busyFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldFlag  <= 1'b0;
      busyCnt   <= '0;
      minorPend <= 1'b0;
    end else if (rstWrite) begin
      heldFlag  <= wrData[0];
      minorPend <= 1'b0;
      if (wrData[0]) busyCnt <= '0;
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end else begin
      minorPend <= cmdAccept && (wrData == CMD_VERSION);
      if (cmdAccept) busyCnt <= BCNT_W'(BUSY_CYCLES);
      else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
    end
  end

  always_comb begin
    qCtl       = '0;
    qCtl.flush = holdReq;
    qCtl.pop   = rdStb && (addr == PORT_REPLY);
    if (rstWrite && !wrData[0] && heldFlag) begin
      qCtl.push = 1'b1;
      qCtl.src  = SRC_READY;
    end else if (cmdAccept && (wrData == CMD_VERSION)) begin
      qCtl.push = 1'b1;
      qCtl.src  = SRC_MAJOR;
    end else if (minorPend && !holdReq) begin
      qCtl.push = 1'b1;
      qCtl.src  = SRC_MINOR;
    end
  end
endmodule

// File: rtl/dsp_host_dp.sv
module dsp_host_dp
  import dsp_host_pkg::*;
#(
  parameter int         FIFO_DEPTH = 4,
  parameter logic [7:0] VER_MAJOR  = 8'd4,
  parameter logic [7:0] VER_MINOR  = 8'd5
) (
  input  logic       clk,
  input  logic       rstN,
  input  queueCtl_t  qCtl,
  input  logic [1:0] addr,
  input  logic       rdStb,
  input  logic       busyFlag,
  output logic       availFlag,
  output logic [7:0] rdData
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int QCNT_W = $clog2(FIFO_DEPTH + 1);

  logic [7:0]        store [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [QCNT_W-1:0] fill;
  logic [7:0]        pushByte;
  logic              doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    unique case (qCtl.src)
      SRC_MAJOR: pushByte = VER_MAJOR;
      SRC_MINOR: pushByte = VER_MINOR;
      default:   pushByte = READY_BYTE;
    endcase
  end

  assign availFlag = (fill != '0);
  assign doPush    = qCtl.push && (fill != QCNT_W'(FIFO_DEPTH));
  assign doPop     = qCtl.pop && availFlag;

  always_ff @(posedge clk) begin
    if (!rstN || qCtl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) begin
        store[wrPtr] <= pushByte;
        wrPtr        <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop) fill <= fill + 1'b1;
      else if (doPop && !doPush) fill <= fill - 1'b1;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (rdStb) begin
      unique case (addr)
        PORT_CMD:   rdData = {busyFlag, 7'b0};
        PORT_REPLY: rdData = availFlag ? store[rdPtr] : EMPTY_BYTE;
        PORT_RSTAT: rdData = {availFlag, 7'b0};
        default:    rdData = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/dsp_host_port.sv
module dsp_host_port
  import dsp_host_pkg::*;
#(
  parameter int         BUSY_CYCLES = 4,
  parameter int         FIFO_DEPTH  = 4,
  parameter logic [7:0] CMD_VERSION = 8'hE1,
  parameter logic [7:0] VER_MAJOR   = 8'd4,
  parameter logic [7:0] VER_MINOR   = 8'd5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  queueCtl_t qCtl;
  logic      heldFlag, busyFlag, availFlag;

  dsp_host_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES),
    .CMD_VERSION(CMD_VERSION)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .qCtl(qCtl), .heldFlag(heldFlag), .busyFlag(busyFlag)
  );

  dsp_host_dp #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .VER_MAJOR(VER_MAJOR),
    .VER_MINOR(VER_MINOR)
  ) dp_i (
    .clk(clk), .rstN(rstN), .qCtl(qCtl), .addr(addr), .rdStb(rdStb),
    .busyFlag(busyFlag), .availFlag(availFlag), .rdData(rdData)
  );
endmodule

// File: rtl/dsp_host_port_chk.sv
module dsp_host_port_chk
  import dsp_host_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] addr,
  input logic       rdStb,
  input logic       wrStb,
  input logic       heldFlag,
  input logic       busyFlag,
  input logic       availFlag
);
  AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    heldFlag |-> !availFlag); // R2

  AST_RELEASE_READY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(heldFlag) |-> availFlag); // R3

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && addr == PORT_CMD && !busyFlag) |=> busyFlag); // R6

  AST_AVAIL_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (availFlag && !(rdStb && addr == PORT_REPLY) && !(wrStb && addr == PORT_RESET))
      |=> availFlag); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!availFlag && !busyFlag && !(wrStb && (addr == PORT_RESET || addr == PORT_CMD)))
      |=> !availFlag); // R8
endmodule

bind dsp_host_port dsp_host_port_chk chk_i (
  .clk(clk), .rstN(rstN), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
  .heldFlag(heldFlag), .busyFlag(busyFlag), .availFlag(availFlag)
);

// File: tb/dsp_host_port_tb_top.sv
module dsp_host_port_tb_top;
  localparam int         BUSY = 4;
  localparam int         DEPTH = 4;
  localparam logic [7:0] VCMD = 8'hE1;
  localparam logic [7:0] MAJ = 8'd4;
  localparam logic [7:0] MIN = 8'd5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       rdStb = 1'b0;
  logic       wrStb = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  int         nRun = 0;
  int         nFail = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  dsp_host_port #(
    .BUSY_CYCLES(BUSY), .FIFO_DEPTH(DEPTH), .CMD_VERSION(VCMD),
    .VER_MAJOR(MAJ), .VER_MINOR(MIN)
  ) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrStb = 1'b1;
    @(posedge clk); #1;
    wrStb = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdStb = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1;
    rdStb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    busRead(2'd1, got); check("R1 busy", got, 8'h00);
    busRead(2'd3, got); check("R1 avail", got, 8'h00);
    busRead(2'd2, got); check("R1 R5 empty read", got, 8'hFF);

    // R2 hold
    busWrite(2'd0, 8'h01);
    busRead(2'd1, got); check("R2 busy in hold", got, 8'h80);
    busWrite(2'd1, VCMD);
    idle(BUSY + 2);
    busRead(2'd3, got); check("R2 cmd ignored in hold", got, 8'h00);

    // R3 release, R4 status, R5 pop
    busWrite(2'd0, 8'h00);
    busRead(2'd3, got); check("R3 R4 ready avail", got, 8'h80);
    busRead(2'd1, got); check("R3 not busy", got, 8'h00);
    busRead(2'd2, got); check("R3 ready byte", got, 8'hAA);
    busRead(2'd3, got); check("R5 drained", got, 8'h00);
    busWrite(2'd0, 8'h00);
    busRead(2'd3, got); check("R3 release without hold", got, 8'h00);

    // R6 busy window, R8 unknown command
    busWrite(2'd1, 8'h00);
    for (int k = 0; k < BUSY; k++) begin
      busRead(2'd1, got); check("R6 busy window", got, 8'h80);
    end
    busRead(2'd1, got); check("R6 busy end", got, 8'h00);
    busRead(2'd3, got); check("R8 no reply", got, 8'h00);

    // R7 pop in the cycle the minor byte is pushed
    busWrite(2'd1, VCMD);
    busRead(2'd2, got); check("R7 major", got, MAJ);
    busRead(2'd3, got); check("R7 minor pending", got, 8'h80);
    busRead(2'd2, got); check("R7 minor", got, MIN);
    busRead(2'd3, got); check("R7 drained", got, 8'h00);

    // R9 write while busy discarded
    idle(BUSY);
    busWrite(2'd1, VCMD);
    busWrite(2'd1, VCMD);
    idle(BUSY + 2);
    busRead(2'd2, got); check("R9 major", got, MAJ);
    busRead(2'd2, got); check("R9 minor", got, MIN);
    busRead(2'd3, got); check("R9 no second reply", got, 8'h00);

    // R7 R8 exhaustive command sweep
    for (int c = 0; c < 256; c++) begin
      busWrite(2'd1, 8'(c));
      idle(BUSY + 2);
      busRead(2'd3, got);
      check((c == int'(VCMD)) ? "R7 sweep" : "R8 sweep", got, (c == int'(VCMD)) ? 8'h80 : 8'h00);
      if (c == int'(VCMD)) begin
        busRead(2'd2, got); check("R7 sweep major", got, MAJ);
        busRead(2'd2, got); check("R7 sweep minor", got, MIN);
      end
    end

    // R10 overflow
    busWrite(2'd0, 8'h01);
    busWrite(2'd0, 8'h00);
    for (int k = 0; k < 3; k++) begin
      busWrite(2'd1, VCMD);
      idle(BUSY + 2);
    end
    busRead(2'd2, got); check("R10 q0", got, 8'hAA);
    busRead(2'd2, got); check("R10 q1", got, MAJ);
    busRead(2'd2, got); check("R10 q2", got, MIN);
    busRead(2'd2, got); check("R10 q3", got, MAJ);
    busRead(2'd3, got); check("R10 overflow dropped", got, 8'h00);

    // R11 hold cancels pending minor
    busWrite(2'd1, VCMD);
    busWrite(2'd0, 8'h01);
    idle(2);
    busWrite(2'd0, 8'h00);
    busRead(2'd2, got); check("R11 ready only", got, 8'hAA);
    busRead(2'd3, got); check("R11 no minor", got, 8'h00);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule